// File: doc/BRIEF.md
# Integer Execute Unit with Safe Divide

This block is the integer execute stage of a 32-bit processor. It takes two operands and a 4-bit operation code and returns one result word. The result covers wrapping add, subtract and multiply, bitwise logic, three masked shifts, upper-immediate placement, and signed divide and remainder. Every operation except a divide with a nonzero divisor completes one cycle after it is accepted. A divide with a nonzero divisor runs through an iterative shift-subtract engine and holds `busy_o` until it finishes. A zero divisor never traps: it returns 0 at once.

A separate combinational path compares the same two operands under a 2-bit condition select and drives `taken_o`. This bit feeds branch resolution in the same cycle, independent of the start/done handshake. The pipeline raises `start_i` for one cycle with the operands valid, and takes `result_o` when `done_o` pulses.

Top module: `exec_unit`

## Requirements
- R1: `op_i` encoding: 0 add, 1 subtract, 2 multiply, 3 divide, 4 remainder, 5 and, 6 or, 7 xor, 8 not, 9 shift left, 10 logical shift right, 11 arithmetic shift right, 12 upper immediate. Codes 13 to 15 complete normally with result 0.
- R2: Add, subtract and multiply wrap modulo 2^32. Multiply keeps the low 32 bits of the product.
- R3: And, or and xor are bitwise on `a_i` and `b_i`. Not returns the complement of `a_i`, whatever the value of `b_i`.
- R4: Shifts move `a_i` by `b_i[4:0]` only. Logical right shift fills with zeros, arithmetic right shift copies bit 31, and a shift by 0 returns `a_i`.
- R5: Upper immediate returns `b_i[17:0]` shifted left by 14, with the low 14 bits zero.
- R6: Divide and remainder are signed, with `a_i` the dividend. The quotient truncates toward zero. The remainder takes the sign of the dividend, so that a = q*b + r and |r| < |b|.
- R7: A divide or remainder whose `b_i` is zero returns 0, with `done_o` at the same latency as a fast operation.
- R8: 0x80000000 divided by -1 returns 0x80000000, and the matching remainder is 0.
- R9: For every operation except a divide by a nonzero divisor, `done_o` is high in the cycle after the accepting clock edge. A divide by a nonzero divisor raises `done_o` 33 cycles later than that. `busy_o` is high from the cycle after a divide is accepted until `done_o`, and `done_o` is never high while `busy_o` is high.
- R10: A `start_i` while `busy_o` is high is ignored. It produces no `done_o`, and the result of the running divide is unchanged.
- R11: `taken_o` depends only on the present inputs. `cmp_i` selects: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal.
- R12: While `rst_ni` is low, `result_o`, `done_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept the operation on this edge when not busy |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand, dividend |
| b_i | input | 32 | Second operand, divisor, shift amount or immediate |
| cmp_i | input | 2 | Branch condition select |
| result_o | output | 32 | Result of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Divide in progress |
| taken_o | output | 1 | Branch condition outcome |

## Verification
On every cycle, assertions check the following:
- that the divide engine is started only when idle;
- that it finishes only after its full iteration count;
- that the final partial remainder is below the divisor magnitude;
- that `done_o` never coincides with `busy_o`;
- that a zero-divisor request completes with 0 on the next cycle.

The arithmetic values themselves can only be shown by the bench's scenarios. These are truncation and sign rules around 0x80000000, -1 and mixed-sign operands, shift masking above 31, the ignored second operand of not, and the branch comparisons at the signed extremes. The same holds for the exact divide latency and the dropping of a start issued mid-divide.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_REM  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOT  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ASHR = 4'd11,
    OP_LUI  = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_GE = 2'd3
  } cmp_e;

  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_DONE = 2'd2
  } div_state_e;

  localparam int unsigned LUI_IMM_W = 18;
endpackage

// File: rtl/exec_alu_fast.sv
module exec_alu_fast import exec_pkg::*; #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned SHW    = $clog2(WIDTH);
  localparam int unsigned LUI_SH = WIDTH - LUI_IMM_W;

  logic [SHW-1:0]   shamt;
  logic [WIDTH-1:0] prod;
  logic [WIDTH-1:0] lui_val;

  assign shamt   = b_i[SHW-1:0];
  assign prod    = a_i * b_i;
  assign lui_val = {b_i[LUI_IMM_W-1:0], {LUI_SH{1'b0}}};

  // divide/remainder land here only with a zero divisor -> 0
  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = prod;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SHL:  res_o = a_i << shamt;
      OP_SHR:  res_o = a_i >> shamt;
      OP_ASHR: res_o = $unsigned($signed(a_i) >>> shamt);
      OP_LUI:  res_o = lui_val;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_SHL && shamt == '0) begin
      AST_SHL_ZERO_IDENT: assert (res_o == a_i); // R4
    end
  end
endmodule

// File: rtl/exec_branch_cmp.sv
module exec_branch_cmp import exec_pkg::*; #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       cmp_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             taken_o
);
  logic eq;
  logic lt;

  assign eq = (a_i == b_i);
  assign lt = ($signed(a_i) < $signed(b_i));

  always_comb begin
    case (cmp_i)
      CMP_EQ:  taken_o = eq;
      CMP_NE:  taken_o = ~eq;
      CMP_LT:  taken_o = lt;
      default: taken_o = ~lt;
    endcase
  end
endmodule

// File: rtl/exec_divider.sv
module exec_divider import exec_pkg::*; #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  localparam int unsigned      CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WIDTH - 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] dvs_q;
  logic             neg_quo_q;
  logic             neg_rem_q;

  logic [WIDTH-1:0] a_mag;
  logic [WIDTH-1:0] b_mag;
  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   diff;
  logic             fits;

  // magnitudes; 0x80000000 stays 0x80000000, valid as unsigned
  assign a_mag   = a_i[WIDTH-1] ? ('0 - a_i) : a_i;
  assign b_mag   = b_i[WIDTH-1] ? ('0 - b_i) : b_i;
  assign shifted = {rem_q, quo_q[WIDTH-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = ~diff[WIDTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= DIV_IDLE;
      cnt_q     <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else begin
      case (state_q)
        DIV_IDLE: begin
          if (start_i) begin
            rem_q     <= '0;
            quo_q     <= a_mag;
            dvs_q     <= b_mag;
            neg_quo_q <= a_i[WIDTH-1] ^ b_i[WIDTH-1];
            neg_rem_q <= a_i[WIDTH-1];
            cnt_q     <= '0;
            state_q   <= DIV_RUN;
          end
        end
        DIV_RUN: begin
          rem_q <= fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
          quo_q <= {quo_q[WIDTH-2:0], fits};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= DIV_DONE;
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != DIV_IDLE);
  assign valid_o = (state_q == DIV_DONE);
  assign quo_o   = neg_quo_q ? ('0 - quo_q) : quo_q;
  assign rem_o   = neg_rem_q ? ('0 - rem_q) : rem_q;

  AST_DIV_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state_q == DIV_IDLE); // R10

  AST_DIV_FULL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == DIV_DONE |-> ($past(state_q) == DIV_RUN && $past(cnt_q) == LAST)); // R9

  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rem_q < dvs_q); // R6
endmodule

// File: rtl/exec_unit.sv
module exec_unit import exec_pkg::*; #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       cmp_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             taken_o
);
  logic [WIDTH-1:0] fast_res;
  logic [WIDTH-1:0] div_quo;
  logic [WIDTH-1:0] div_rem;
  logic             div_busy;
  logic             div_valid;
  logic             is_div_op;
  logic             accept;
  logic             div_launch;
  logic             rem_sel_q;

  assign is_div_op  = (op_i == OP_DIV) || (op_i == OP_REM);
  assign accept     = start_i && !div_busy;
  assign div_launch = accept && is_div_op && (b_i != '0);
  assign busy_o     = div_busy;

  exec_alu_fast #(.WIDTH(WIDTH)) u_fast (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (fast_res)
  );

  exec_divider #(.WIDTH(WIDTH)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_launch),
    .a_i     (a_i),
    .b_i     (b_i),
    .busy_o  (div_busy),
    .valid_o (div_valid),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  exec_branch_cmp #(.WIDTH(WIDTH)) u_cmp (
    .cmp_i   (cmp_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .taken_o (taken_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      done_o    <= 1'b0;
      rem_sel_q <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (div_valid) begin
        result_o <= rem_sel_q ? div_rem : div_quo;
        done_o   <= 1'b1;
      end else if (accept && !div_launch) begin
        result_o <= fast_res;
        done_o   <= 1'b1;
      end
      if (div_launch) rem_sel_q <= (op_i == OP_REM);
    end
  end

  AST_BUSY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R9

  AST_FAST_DONE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !div_launch) |=> done_o); // R9

  AST_ZERO_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_div_op && b_i == '0) |=> (done_o && result_o == '0)); // R7
endmodule

// File: tb/exec_unit_tb_top.sv
module exec_unit_tb_top;
  localparam int W = 32;
  localparam logic [31:0] IMIN = 32'h8000_0000;
  localparam logic [31:0] IMAX = 32'h7FFF_FFFF;
  localparam int FAST_LAT = 1;
  localparam int DIV_LAT  = W + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    op_i = '0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic [1:0]    cmp_i = '0;
  logic [W-1:0]  result_o;
  logic          done_o;
  logic          busy_o;
  logic          taken_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  exec_unit #(.WIDTH(W)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .cmp_i    (cmp_i),
    .result_o (result_o),
    .done_o   (done_o),
    .busy_o   (busy_o),
    .taken_o  (taken_o)
  );

  function automatic logic [31:0] ref_res(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a * b;
      4'd3: begin
        if (b == 0) return 32'd0;
        if (a == IMIN && b == 32'hFFFF_FFFF) return IMIN;
        return 32'($signed(a) / $signed(b));
      end
      4'd4: begin
        if (b == 0) return 32'd0;
        if (a == IMIN && b == 32'hFFFF_FFFF) return 32'd0;
        return 32'($signed(a) % $signed(b));
      end
      4'd5:  return a & b;
      4'd6:  return a | b;
      4'd7:  return a ^ b;
      4'd8:  return ~a;
      4'd9:  return a << b[4:0];
      4'd10: return a >> b[4:0];
      4'd11: return 32'($signed(a) >>> b[4:0]);
      4'd12: return {b[17:0], 14'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    if ((op == 4'd3 || op == 4'd4) && b == 0) return "R7";
    if ((op == 4'd3 || op == 4'd4) && a == IMIN && b == 32'hFFFF_FFFF) return "R8";
    case (op)
      4'd0, 4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R6";
      4'd5, 4'd6, 4'd7, 4'd8: return "R3";
      4'd9, 4'd10, 4'd11: return "R4";
      4'd12: return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic logic ref_taken(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      2'd0: return a == b;
      2'd1: return a != b;
      2'd2: return $signed(a) < $signed(b);
      default: return $signed(a) >= $signed(b);
    endcase
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFF_FFFF;
      3: return IMIN;
      4: return IMAX;
      5: return 32'($urandom_range(0, 40)) - 32'd20;
      default: return $urandom;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    int lat;
    int exp_lat;
    logic [31:0] exp;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    exp = ref_res(op, a, b);
    exp_lat = ((op == 4'd3 || op == 4'd4) && b != 0) ? DIV_LAT : FAST_LAT;
    check(result_o == exp, tag_of(op, a, b), result_o, exp);
    check(lat == exp_lat, "R9", 32'(lat), 32'(exp_lat));
  endtask

  task automatic run_cmp(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    logic exp;
    @(negedge clk);
    cmp_i = c; a_i = a; b_i = b;
    #1;
    exp = ref_taken(c, a, b);
    check(taken_o == exp, "R11", 32'(taken_o), 32'(exp));
  endtask

  // R10: a start issued mid-divide is dropped
  task automatic busy_start_test();
    int lat;
    int extra;
    @(negedge clk);
    op_i = 4'd3; a_i = 32'd100; b_i = 32'd7; start_i = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b1, "R9", 32'(busy_o), 32'd1);
    op_i = 4'd0; a_i = 32'd1; b_i = 32'd2;
    @(negedge clk);
    start_i = 1'b0;
    lat = 2;
    extra = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(lat == DIV_LAT, "R10", 32'(lat), 32'(DIV_LAT));
    check(result_o == 32'd14, "R10", result_o, 32'd14);
    @(negedge clk);
    if (done_o) extra++;
    @(negedge clk);
    if (done_o) extra++;
    check(extra == 0, "R10", 32'(extra), 32'd0);
    check(busy_o == 1'b0, "R9", 32'(busy_o), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #5;
    check(result_o == '0, "R12", result_o, 32'd0);
    check(done_o == 1'b0, "R12", 32'(done_o), 32'd0);
    check(busy_o == 1'b0, "R12", 32'(busy_o), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 wrap
    run_op(4'd0, IMAX, 32'd1);
    run_op(4'd1, 32'd0, 32'd1);
    run_op(4'd2, 32'h0001_0000, 32'h0001_0000);
    run_op(4'd2, 32'hFFFF_FFFD, 32'd7);
    // R6 signs and truncation
    run_op(4'd3, 32'd20, 32'd3);
    run_op(4'd3, 32'hFFFF_FFEC, 32'd3);
    run_op(4'd3, 32'd20, 32'hFFFF_FFFD);
    run_op(4'd3, 32'hFFFF_FFEC, 32'hFFFF_FFFD);
    run_op(4'd4, 32'd20, 32'd3);
    run_op(4'd4, 32'hFFFF_FFEC, 32'd3);
    run_op(4'd4, 32'd20, 32'hFFFF_FFFD);
    run_op(4'd3, IMIN, 32'd1);
    run_op(4'd3, IMIN, IMIN);
    run_op(4'd4, IMAX, IMIN);
    // R7 zero divisor
    run_op(4'd3, 32'd5, 32'd0);
    run_op(4'd4, IMIN, 32'd0);
    // R8
    run_op(4'd3, IMIN, 32'hFFFF_FFFF);
    run_op(4'd4, IMIN, 32'hFFFF_FFFF);
    // R3 not ignores b
    run_op(4'd8, 32'h1234_5678, 32'd0);
    run_op(4'd8, 32'h1234_5678, 32'hFFFF_FFFF);
    // R4 shifts and masking
    run_op(4'd11, 32'hFFFF_FF00, 32'd4);
    run_op(4'd10, 32'h0000_0080, 32'd4);
    run_op(4'd10, IMIN, 32'd31);
    run_op(4'd9, 32'd1, 32'd33);
    run_op(4'd9, 32'hDEAD_BEEF, 32'd0);
    run_op(4'd11, IMIN, 32'hFFFF_FFFF);
    // R5
    run_op(4'd12, 32'd0, 32'h10);
    run_op(4'd12, 32'd0, 32'hFFFF_FFFF);
    // R1 unused codes
    run_op(4'd13, 32'd9, 32'd9);
    run_op(4'd14, 32'hFFFF_FFFF, 32'd1);
    run_op(4'd15, IMIN, IMAX);
    // R11 extremes
    run_cmp(2'd2, IMIN, IMAX);
    run_cmp(2'd3, IMIN, IMAX);
    run_cmp(2'd3, 32'd5, 32'd5);
    run_cmp(2'd0, 32'd5, 32'd5);
    run_cmp(2'd1, 32'd5, 32'd5);
    run_cmp(2'd2, 32'hFFFF_FFFF, 32'd0);

    busy_start_test();

    for (int i = 0; i < 400; i++) begin
      run_op(4'($urandom_range(0, 15)), pick(), pick());
    end
    for (int i = 0; i < 200; i++) begin
      run_cmp(2'($urandom_range(0, 3)), pick(), pick());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule